// File: doc/BRIEF.md
# Randomized Matrix Product Checker

This block decides at run time whether a claimed product `C` of two small square unsigned integer matrices `A` and `B` is right, without redoing the cubic-cost multiplication. It draws a random 0/1 vector `r` for each trial and also forms its bitwise complement. For each of the two vectors it computes `A*(B*v)` and `C*v` using only matrix-vector products, and it compares the two results row by row. A mismatch in any row, in any trial, raises the error flag.

A client places the three matrices on flat input buses and pulses `start_i` while the block is idle. The block copies the operands into its own registers, runs `TRIALS` trials of four cycles each, then pulses `done_o` for one cycle. `err_o` then holds the verdict until the next accepted start. The pair of complementary vectors means that a `C` with exactly one wrong element is always caught in the first trial, whatever random bits are drawn. A single random vector would only catch it half the time. Random bits come from a 16-bit maximal-length shift register. It starts from a nonzero seed and advances once per trial.

Top module: `freivalds_checker`

## Requirements
- R1: When the block is idle, a high `start_i` at a rising clock edge is accepted. `busy_o` is high in the following cycle. The operands are captured at that edge. Element (i,j) of each matrix is at bits `[(i*N+j)*W +: W]` of its bus, with W = `DW` for A and B and W = `2*DW+clog2(N)` for C.
- R2: `done_o` rises exactly `4*TRIALS` clock cycles after the edge that accepted the start, and it stays high for exactly one cycle.
- R3: When C equals A*B exactly, `err_o` is 0 at done. This includes the case where every element of A and B is 255, so no internal sum overflows.
- R4: When C differs from A*B in exactly one element, at any position and by any amount, `err_o` is 1 at done.
- R5: A `start_i` pulse while `busy_o` is high is ignored. A change on `a_i`, `b_i` or `c_i` while busy does not affect the result, and no extra `done_o` pulse follows.
- R6: `err_o` keeps its value from the done cycle until the next accepted start.
- R7: A synchronous active-high `rst_i` drives `busy_o`, `done_o` and `err_o` low and aborts a check in progress, so that no `done_o` pulse follows it.
- R8: `busy_o` is high from the cycle after acceptance up to and including the done cycle, and it is low in the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Request a check; only honoured when idle |
| a_i | input | N*N*DW | Left factor, row-major |
| b_i | input | N*N*DW | Right factor, row-major |
| c_i | input | N*N*(2*DW+clog2(N)) | Claimed product, row-major |
| busy_o | output | 1 | A check is in progress |
| done_o | output | 1 | One-cycle pulse when all trials have finished |
| err_o | output | 1 | Verdict: 1 when any trial found a mismatch |

## Verification
The bench corrupts each of the nine positions of C in turn, flipping a different bit each time. A design that used only the plain random vector and dropped its complement would miss some of these corruptions, depending on the drawn bits. All-255 operands go after intermediate sums that are too narrow: a design with truncated accumulators would report an error on a correct product. A start pulse arrives in mid-check, together with C swapped for its correct value. A design that restarted or re-read its inputs would then clear the error, shift `done_o`, or pulse `done_o` twice. A reset in mid-check after the error bit is set must clear `err_o` and suppress `done_o`.

// File: rtl/freivalds_pkg.sv
`timescale 1ns/1ps
package freivalds_pkg;

    // Sequencer states: one pass through BR..CMP is one trial
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BR,
        ST_ABR,
        ST_CR,
        ST_CMP,
        ST_DONE
    } fv_state_e;

    // Lane 0 works on the random vector, lane 1 on its complement
    localparam int unsigned NLANE = 2;

    // Control decoded from the sequencer state
    typedef struct packed {
        logic accept;
        logic advance;
        logic last;
    } fv_ctl_t;

    // Width that holds a sum of 'terms' values each 'term_w' bits wide
    function automatic int unsigned acc_w(int unsigned term_w, int unsigned terms);
        return term_w + ((terms > 1) ? $clog2(terms) : 0);
    endfunction

    // Width of one element of an exact product of two dw-bit matrices
    function automatic int unsigned c_elem_w(int unsigned dw, int unsigned n);
        return acc_w(2 * dw, n);
    endfunction

    function automatic int unsigned max_w(int unsigned x, int unsigned y);
        return (x > y) ? x : y;
    endfunction

endpackage

// File: rtl/fv_lfsr.sv
`timescale 1ns/1ps
module fv_lfsr #(
    parameter int unsigned       W     = 16,
    parameter logic [W-1:0]      POLY  = 'hB400,
    parameter logic [W-1:0]      SEED  = 'hACE1,
    parameter int unsigned       OUT_W = 3
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             step_i,
    output logic [OUT_W-1:0] bits_o
);
    logic [W-1:0] state_q;

    // Galois form, shifting right; POLY holds the feedback taps
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= SEED;
        end else if (step_i) begin
            state_q <= (state_q >> 1) ^ (state_q[0] ? POLY : '0);
        end
    end

    assign bits_o = state_q[OUT_W-1:0];
endmodule

// File: rtl/fv_row_mac.sv
`timescale 1ns/1ps
module fv_row_mac
    import freivalds_pkg::*;
#(
    parameter  int unsigned N  = 3,
    parameter  int unsigned MW = 8,
    parameter  int unsigned VW = 10,
    localparam int unsigned OW = acc_w(MW + VW, N)
) (
    input  logic [N*MW-1:0] row_i,
    input  logic [N*VW-1:0] vec_i,
    output logic [OW-1:0]   dot_o
);
    // Dot product of one matrix row with the vector, wide enough to never wrap
    always_comb begin
        dot_o = '0;
        for (int j = 0; j < N; j++) begin
            dot_o = dot_o + (OW'(row_i[j*MW +: MW]) * OW'(vec_i[j*VW +: VW]));
        end
    end
endmodule

// File: rtl/fv_matvec.sv
`timescale 1ns/1ps
module fv_matvec
    import freivalds_pkg::*;
#(
    parameter  int unsigned N  = 3,
    parameter  int unsigned MW = 8,
    parameter  int unsigned VW = 10,
    localparam int unsigned OW = acc_w(MW + VW, N)
) (
    input  logic [N*N*MW-1:0] mat_i,
    input  logic [N*VW-1:0]   vec_i,
    output logic [N*OW-1:0]   res_o
);
    for (genvar i = 0; i < N; i++) begin : g_row
        fv_row_mac #(
            .N  (N),
            .MW (MW),
            .VW (VW)
        ) u_mac (
            .row_i (mat_i[i*N*MW +: N*MW]),
            .vec_i (vec_i),
            .dot_o (res_o[i*OW +: OW])
        );
    end
endmodule

// File: rtl/fv_cmp.sv
`timescale 1ns/1ps
module fv_cmp
    import freivalds_pkg::*;
#(
    parameter  int unsigned N  = 3,
    parameter  int unsigned LW = 20,
    parameter  int unsigned RW = 21,
    localparam int unsigned XW = max_w(LW, RW)
) (
    input  logic [N*LW-1:0] lhs_i,
    input  logic [N*RW-1:0] rhs_i,
    output logic            miss_o
);
    always_comb begin
        miss_o = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (XW'(lhs_i[i*LW +: LW]) != XW'(rhs_i[i*RW +: RW])) begin
                miss_o = 1'b1;
            end
        end
    end
endmodule

// File: rtl/freivalds_checker.sv
`timescale 1ns/1ps
module freivalds_checker
    import freivalds_pkg::*;
#(
    parameter  int unsigned N         = 3,
    parameter  int unsigned DW        = 8,
    parameter  int unsigned TRIALS    = 4,
    parameter  int unsigned RNG_W     = 16,
    parameter  logic [15:0] RNG_SEED  = 16'hACE1,
    localparam int unsigned CW        = c_elem_w(DW, N)
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              start_i,
    input  logic [N*N*DW-1:0] a_i,
    input  logic [N*N*DW-1:0] b_i,
    input  logic [N*N*CW-1:0] c_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o
);
    // B*v element width (v is 0/1), A*(B*v) width, C*v width
    localparam int unsigned VW  = acc_w(DW, N);
    localparam int unsigned AW  = acc_w(DW + VW, N);
    localparam int unsigned CRW = acc_w(CW + 1, N);
    localparam int unsigned TCW = (TRIALS > 1) ? $clog2(TRIALS) : 1;

    fv_state_e         state_q;
    logic [TCW-1:0]    trial_q;
    logic              err_q;
    fv_ctl_t           ctl;
    logic [N*N*DW-1:0] a_q;
    logic [N*N*DW-1:0] b_q;
    logic [N*N*CW-1:0] c_q;
    logic [N-1:0]      rnd_bits;
    logic [NLANE-1:0]  miss;

    always_comb begin
        ctl.accept  = (state_q == ST_IDLE) && start_i;
        ctl.advance = (state_q == ST_CMP);
        ctl.last    = (trial_q == TCW'(TRIALS - 1));
    end

    // Sequencer
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= ST_IDLE;
            trial_q <= '0;
            err_q   <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (ctl.accept) begin
                        state_q <= ST_BR;
                        trial_q <= '0;
                        err_q   <= 1'b0;
                    end
                end
                ST_BR:  state_q <= ST_ABR;
                ST_ABR: state_q <= ST_CR;
                ST_CR:  state_q <= ST_CMP;
                ST_CMP: begin
                    err_q <= err_q | (|miss);
                    if (ctl.last) begin
                        state_q <= ST_DONE;
                    end else begin
                        state_q <= ST_BR;
                        trial_q <= trial_q + 1'b1;
                    end
                end
                ST_DONE: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Operand capture: only at acceptance, so the buses are free while busy
    always_ff @(posedge clk_i) begin
        if (ctl.accept) begin
            a_q <= a_i;
            b_q <= b_i;
            c_q <= c_i;
        end
    end

    fv_lfsr #(
        .W     (RNG_W),
        .POLY  (RNG_W'('hB400)),
        .SEED  (RNG_W'(RNG_SEED)),
        .OUT_W (N)
    ) u_rng (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .step_i (ctl.advance),
        .bits_o (rnd_bits)
    );

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        logic [N-1:0]      sel_bits;
        logic [N*VW-1:0]   sel_vec;
        logic [N*N*DW-1:0] mv_mat;
        logic [N*VW-1:0]   mv_vec;
        logic [N*AW-1:0]   mv_res;
        logic [N*CRW-1:0]  cv_res;
        logic [N*VW-1:0]   br_q;
        logic [N*AW-1:0]   abr_q;
        logic [N*CRW-1:0]  cr_q;

        assign sel_bits = (g == 0) ? rnd_bits : ~rnd_bits;

        always_comb begin
            sel_vec = '0;
            for (int j = 0; j < N; j++) begin
                sel_vec[j*VW] = sel_bits[j];
            end
        end

        // One multiplying unit serves B*v in BR and A*(B*v) in ABR
        assign mv_mat = (state_q == ST_ABR) ? a_q  : b_q;
        assign mv_vec = (state_q == ST_ABR) ? br_q : sel_vec;

        fv_matvec #(
            .N  (N),
            .MW (DW),
            .VW (VW)
        ) u_mv (
            .mat_i (mv_mat),
            .vec_i (mv_vec),
            .res_o (mv_res)
        );

        // C*v needs only select-and-add: 1-bit vector elements
        fv_matvec #(
            .N  (N),
            .MW (CW),
            .VW (1)
        ) u_cv (
            .mat_i (c_q),
            .vec_i (sel_bits),
            .res_o (cv_res)
        );

        always_ff @(posedge clk_i) begin
            case (state_q)
                ST_BR: begin
                    for (int i = 0; i < N; i++) begin
                        br_q[i*VW +: VW] <= mv_res[i*AW +: VW];
                    end
                end
                ST_ABR:  abr_q <= mv_res;
                ST_CR:   cr_q  <= cv_res;
                default: ;
            endcase
        end

        fv_cmp #(
            .N  (N),
            .LW (AW),
            .RW (CRW)
        ) u_cmp (
            .lhs_i  (abr_q),
            .rhs_i  (cr_q),
            .miss_o (miss[g])
        );
    end

    assign busy_o = (state_q != ST_IDLE);
    assign done_o = (state_q == ST_DONE);
    assign err_o  = err_q;
endmodule

// File: rtl/freivalds_checker_sva.sv
`timescale 1ns/1ps
module freivalds_checker_sva #(
    parameter int unsigned TRIALS = 4
) (
    input logic clk_i,
    input logic rst_i,
    input logic start_i,
    input logic busy_o,
    input logic done_o,
    input logic err_o
);
    logic [31:0] run_cnt;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            run_cnt <= '0;
        end else if (!busy_o && start_i) begin
            run_cnt <= '0;
        end else if (busy_o) begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    a_r1_accept: assert property (@(posedge clk_i) disable iff (rst_i)
        (!busy_o && start_i) |=> busy_o);

    a_r2_latency: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |-> (run_cnt == 32'(4 * TRIALS)));

    a_r2_done_pulse: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |=> !done_o);

    a_r5_no_restart: assert property (@(posedge clk_i) disable iff (rst_i)
        (busy_o && !done_o) |=> busy_o);

    a_r6_err_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        !busy_o |=> (busy_o || $stable(err_o)));

    a_r7_reset: assert property (@(posedge clk_i)
        $past(rst_i) |-> (!busy_o && !done_o && !err_o));

    a_r8_busy_end: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(busy_o) |-> $past(done_o));
endmodule

bind freivalds_checker freivalds_checker_sva #(.TRIALS(TRIALS)) u_sva (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .start_i (start_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .err_o   (err_o)
);

// File: tb/freivalds_checker_tb_top.sv
`timescale 1ns/1ps
module freivalds_checker_tb_top;
    localparam int N  = 3;
    localparam int DW = 8;
    localparam int K  = 4;
    localparam int CW = 2 * DW + 2;

    typedef struct {
        bit    exp_err;
        int    acc;
        string tag;
    } item_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [N*N*DW-1:0] a_flat = '0;
    logic [N*N*DW-1:0] b_flat = '0;
    logic [N*N*CW-1:0] c_flat = '0;
    logic busy_o, done_o, err_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int done_seen = 0;
    item_t sb_q[$];
    int unsigned ma [N][N];
    int unsigned mb [N][N];
    int unsigned mc [N][N];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    freivalds_checker #(.N(N), .DW(DW), .TRIALS(K)) dut_i (
        .clk_i   (clk),
        .rst_i   (rst),
        .start_i (start),
        .a_i     (a_flat),
        .b_i     (b_flat),
        .c_i     (c_flat),
        .busy_o  (busy_o),
        .done_o  (done_o),
        .err_o   (err_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Monitor: pops the scoreboard on every done pulse
    always @(negedge clk) begin
        if (!rst && done_o) begin
            done_seen++;
            if (sb_q.size() == 0) begin
                chk(1'b0, "R5", "unexpected done pulse", 1, 0);
            end else begin
                item_t it;
                it = sb_q.pop_front();
                chk(err_o == it.exp_err, (it.exp_err ? "R4" : "R3"), it.tag,
                    err_o, it.exp_err);
                chk((cyc - it.acc) == 4 * K, "R2", {it.tag, " latency"},
                    cyc - it.acc, 4 * K);
            end
        end
    end

    task automatic mul_ab();
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++) begin
                mc[i][j] = 0;
                for (int k = 0; k < N; k++) mc[i][j] += ma[i][k] * mb[k][j];
            end
    endtask

    task automatic rand_ab();
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++) begin
                ma[i][j] = $urandom_range(0, 255);
                mb[i][j] = $urandom_range(0, 255);
            end
    endtask

    task automatic pack_all();
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++) begin
                a_flat[(i*N+j)*DW +: DW] = DW'(ma[i][j]);
                b_flat[(i*N+j)*DW +: DW] = DW'(mb[i][j]);
                c_flat[(i*N+j)*CW +: CW] = CW'(mc[i][j]);
            end
    endtask

    // Driver: starts one check, pushes the expected verdict, waits for the end
    task automatic run_check(input string tag, input bit exp_err);
        item_t it;
        pack_all();
        @(negedge clk);
        start = 1'b1;
        @(posedge clk);
        #1;
        it.exp_err = exp_err;
        it.acc     = cyc;
        it.tag     = tag;
        sb_q.push_back(it);
        @(negedge clk);
        start = 1'b0;
        chk(busy_o == 1'b1, "R1", {tag, " busy after accept"}, busy_o, 1);
        while (!done_o) @(negedge clk);
        @(negedge clk);
        chk(done_o == 1'b0, "R2", {tag, " done one cycle"}, done_o, 0);
        chk(busy_o == 1'b0, "R8", {tag, " idle after done"}, busy_o, 0);
        repeat (2) @(negedge clk);
        chk(err_o == exp_err, "R6", {tag, " verdict held"}, err_o, exp_err);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog (all requirements): actual=timeout expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd7));
        repeat (3) @(negedge clk);
        // R7: reset state
        chk(busy_o == 1'b0, "R7", "busy in reset", busy_o, 0);
        chk(done_o == 1'b0, "R7", "done in reset", done_o, 0);
        chk(err_o == 1'b0, "R7", "err in reset", err_o, 0);
        rst = 1'b0;

        // R3: identity times random matrix
        rand_ab();
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++) ma[i][j] = (i == j) ? 1 : 0;
        mul_ab();
        run_check("identity correct", 1'b0);

        // R3: random correct products
        for (int t = 0; t < 3; t++) begin
            rand_ab();
            mul_ab();
            run_check("random correct", 1'b0);
        end

        // R3: largest operands, widest sums
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++) begin
                ma[i][j] = 255;
                mb[i][j] = 255;
            end
        mul_ab();
        run_check("all-255 correct", 1'b0);

        // R4: one corrupted element at every position
        for (int p = 0; p < N * N; p++) begin
            rand_ab();
            mul_ab();
            mc[p / N][p % N] ^= (1 << ((p * 2) % CW));
            run_check("single element corrupt", 1'b1);
        end

        // R4: zero operands, C has a single 1
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++) begin
                ma[i][j] = 0;
                mb[i][j] = 0;
                mc[i][j] = 0;
            end
        mc[1][2] = 1;
        run_check("zero with one stray", 1'b1);

        // R5: start and operand changes while busy are ignored
        begin
            item_t it;
            int base;
            rand_ab();
            mul_ab();
            mc[0][1] += 3;
            pack_all();
            @(negedge clk);
            start = 1'b1;
            @(posedge clk);
            #1;
            it.exp_err = 1'b1;
            it.acc     = cyc;
            it.tag     = "R5 busy restart ignored";
            sb_q.push_back(it);
            @(negedge clk);
            start = 1'b0;
            repeat (2) @(negedge clk);
            mc[0][1] -= 3;
            pack_all();
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            base = done_seen;
            repeat (4 * K + 6) @(negedge clk);
            chk(done_seen - base == 1, "R5", "done count after busy start",
                done_seen - base, 1);
            chk(err_o == 1'b1, "R5", "captured operands kept", err_o, 1);
        end

        // R7: reset in mid-check clears the verdict and suppresses done
        begin
            item_t it;
            int base;
            rand_ab();
            mul_ab();
            mc[2][0] ^= 1;
            pack_all();
            @(negedge clk);
            start = 1'b1;
            @(posedge clk);
            #1;
            it.exp_err = 1'b1;
            it.acc     = cyc;
            it.tag     = "aborted";
            sb_q.push_back(it);
            @(negedge clk);
            start = 1'b0;
            repeat (5) @(negedge clk);
            chk(err_o == 1'b1, "R4", "error raised in first trial", err_o, 1);
            rst = 1'b1;
            sb_q.delete();
            @(negedge clk);
            chk(busy_o == 1'b0, "R7", "busy after mid reset", busy_o, 0);
            chk(err_o == 1'b0, "R7", "err after mid reset", err_o, 0);
            @(negedge clk);
            rst = 1'b0;
            base = done_seen;
            repeat (4 * K + 4) @(negedge clk);
            chk(done_seen == base, "R7", "no done after abort", done_seen - base, 0);
            chk(busy_o == 1'b0, "R8", "idle after abort", busy_o, 0);
        end

        // Normal operation resumes after the abort
        rand_ab();
        mul_ab();
        run_check("after abort correct", 1'b0);

        finish_run();
    end
endmodule